// File: doc/BRIEF.md
# Nonvolatile Backup Sequencing Controller

This controller decides when a fast SRAM is copied into its shadow nonvolatile array (a store) and when the shadow copy is loaded back into the SRAM (a recall). It watches four things: a synchronized power-good flag, the level of a shared open-drain busy line, the SRAM access strobes, and one-cycle software store or recall requests. It drives a pull-down enable for the busy line, an inhibit signal that locks the SRAM out, and one strobe for each phase of the array model.

A store has two phases: erase, then program. A recall also has two: clear the SRAM, then transfer the nonvolatile data into it. Each phase lasts a fixed number of clock cycles set by a parameter. Three sources can start a store:

- **Automatic:** the power-good flag falls.
- **External:** another agent holds the busy line low.
- **Software:** a software store request.

The automatic and external stores run only when the SRAM has been written since the last completed store. A software store always runs.

A recall starts when power-good rises, and on software request. An external request opens a grace window in which SRAM traffic continues. After any external request, the SRAM stays locked until the busy line goes high again.

Top module: `nv_backup_seq`

## Requirements
- R1: After reset, `sram_inhibit` is 1, `busy_pd` is 0 and every phase strobe is 0. This holds while `pwr_ok` stays 0.
- R2: While the controller waits for power, `pwr_ok` at 1 starts a recall. `ph_clear` is high for CLR_CYC cycles, then `ph_transfer` is high for XFER_CYC cycles. `sram_inhibit` is 1 throughout, and 0 afterwards if `pwr_ok` is still 1.
- R3: In normal operation, a `sw_recall` pulse starts the same clear-then-transfer recall.
- R4: In normal operation, a `sw_store` pulse starts a store whether or not a write has occurred. `ph_erase` is high for ERASE_CYC cycles, then `ph_program` is high for PROG_CYC cycles. `busy_pd` is 1 during both phases. Afterwards `busy_pd` is 0 and `sram_inhibit` is 0.
- R5: If `pwr_ok` falls while a write is pending, `busy_pd` goes to 1 for CHECK_CYC cycles. If the busy line is low at the end of that time, a store follows. `sram_inhibit` then stays 1 until power returns.
- R6: If `pwr_ok` falls while no write is pending, no store runs and `sram_inhibit` goes to 1.
- R7: If the busy line is still high at the end of the check time, `busy_pd` returns to 0 and no store phase occurs.
- R8: If the busy line is low for ASSERT_CYC consecutive cycles in normal operation and a write is pending, a grace window of DLY_CYC cycles follows. During the window `sram_inhibit` stays 0. The store starts when the window ends.
- R9: During the grace window, `acc_strobe` or `wr_req` ends the window, and `ph_erase` rises on the next cycle. While `wr_req` is high in the window, `sram_inhibit` is 1 in that same cycle, so the write is not performed.
- R10: After an external request, `sram_inhibit` stays 1 while the busy line is low. It returns to 0 one cycle after the line is seen high.
- R11: An external request while no write is pending runs no store, but the SRAM is still locked as in R10.
- R12: A write counts only when `wr_req` is 1 while `sram_inhibit` is 0. A completed store clears the pending-write flag, so a later external request with no new write runs no store.
- R13: While `pwr_ok` is 0, a low busy line starts nothing: no phase strobe and no `busy_pd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Synchronized flag: supply is above the switch threshold |
| busy_in | input | 1 | Sensed level of the shared open-drain busy line (1 = high) |
| acc_strobe | input | 1 | SRAM address or control transition |
| wr_req | input | 1 | SRAM write cycle request |
| sw_store | input | 1 | Software store request pulse |
| sw_recall | input | 1 | Software recall request pulse |
| busy_pd | output | 1 | Pull the busy line low |
| sram_inhibit | output | 1 | Lock the SRAM out of reads and writes |
| ph_erase | output | 1 | Store erase phase strobe |
| ph_program | output | 1 | Store program phase strobe |
| ph_clear | output | 1 | Recall SRAM clear phase strobe |
| ph_transfer | output | 1 | Recall transfer phase strobe |

## Verification
A wrong pending-write flag shows on the first automatic or external request after it goes wrong. It shows up as a store that runs when it should be skipped, or as a missing store, and appears within ASSERT_CYC plus DLY_CYC cycles. A wrong phase counter shows as a strobe run whose length differs from its parameter, and is visible when that strobe falls. A missed lock release, or a missed exit from the grace window, shows on `sram_inhibit` or `ph_erase` one cycle after the triggering input.

// File: rtl/nv_backup_seq.sv
module nv_backup_seq #(
  parameter int ERASE_CYC  = 8,
  parameter int PROG_CYC   = 12,
  parameter int CLR_CYC    = 4,
  parameter int XFER_CYC   = 6,
  parameter int ASSERT_CYC = 5,
  parameter int DLY_CYC    = 10,
  parameter int CHECK_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic busy_in,
  input  logic acc_strobe,
  input  logic wr_req,
  input  logic sw_store,
  input  logic sw_recall,
  output logic busy_pd,
  output logic sram_inhibit,
  output logic ph_erase,
  output logic ph_program,
  output logic ph_clear,
  output logic ph_transfer
);
  localparam int M1 = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M2 = (CLR_CYC > XFER_CYC) ? CLR_CYC : XFER_CYC;
  localparam int M3 = (DLY_CYC > CHECK_CYC) ? DLY_CYC : CHECK_CYC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M4 > M3) ? M4 : M3;
  localparam int CW = $clog2(MX + 1);
  localparam int LW = $clog2(ASSERT_CYC + 1);

  typedef enum logic [3:0] {
    S_OFF, S_CLR, S_XFER, S_RUN, S_DLY, S_CHK, S_ERASE, S_PROG, S_LOCK
  } st_t;
  typedef enum logic [1:0] {SRC_SW, SRC_EXT, SRC_AUTO} src_t;

  st_t            st;
  src_t           src;
  logic [CW-1:0]  cnt;
  logic [LW-1:0]  lowcnt;
  logic           dirty;

  assign sram_inhibit = (st == S_DLY) ? wr_req : (st != S_RUN);
  assign busy_pd      = (st == S_CHK) || (st == S_ERASE) || (st == S_PROG);
  assign ph_erase     = (st == S_ERASE);
  assign ph_program   = (st == S_PROG);
  assign ph_clear     = (st == S_CLR);
  assign ph_transfer  = (st == S_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      src    <= SRC_SW;
      cnt    <= '0;
      lowcnt <= '0;
      dirty  <= 1'b0;
    end else begin
      if (wr_req && !sram_inhibit) dirty <= 1'b1;
      lowcnt <= (st == S_RUN && !busy_in) ? lowcnt + 1'b1 : '0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (st)
        S_OFF: if (pwr_ok) begin st <= S_CLR; cnt <= CW'(CLR_CYC - 1); end
        S_CLR: if (cnt == '0) begin st <= S_XFER; cnt <= CW'(XFER_CYC - 1); end
        S_XFER: if (cnt == '0) st <= pwr_ok ? S_RUN : S_OFF;
        S_RUN: begin
          if (!pwr_ok) begin
            lowcnt <= '0;
            src    <= SRC_AUTO;
            if (dirty) begin st <= S_CHK; cnt <= CW'(CHECK_CYC - 1); end
            else st <= S_OFF;
          end else if (sw_store) begin
            lowcnt <= '0;
            src    <= SRC_SW;
            st     <= S_ERASE;
            cnt    <= CW'(ERASE_CYC - 1);
          end else if (sw_recall) begin
            lowcnt <= '0;
            st     <= S_CLR;
            cnt    <= CW'(CLR_CYC - 1);
          end else if (!busy_in && lowcnt == LW'(ASSERT_CYC - 1)) begin
            lowcnt <= '0;
            src    <= SRC_EXT;
            if (dirty) begin st <= S_DLY; cnt <= CW'(DLY_CYC - 1); end
            else st <= S_LOCK;
          end
        end
        S_DLY: if (acc_strobe || wr_req || cnt == '0) begin
          st  <= S_ERASE;
          cnt <= CW'(ERASE_CYC - 1);
        end
        S_CHK: if (cnt == '0) begin
          if (!busy_in) begin st <= S_ERASE; cnt <= CW'(ERASE_CYC - 1); end
          else st <= S_OFF;
        end
        S_ERASE: if (cnt == '0) begin st <= S_PROG; cnt <= CW'(PROG_CYC - 1); end
        S_PROG: if (cnt == '0) begin
          dirty <= 1'b0;
          case (src)
            SRC_EXT:  st <= S_LOCK;
            SRC_AUTO: st <= S_OFF;
            default:  st <= pwr_ok ? S_RUN : S_OFF;
          endcase
        end
        S_LOCK: if (busy_in) st <= pwr_ok ? S_RUN : S_OFF;
        default: st <= S_OFF;
      endcase
    end
  end

  a_r4_pd_while_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_erase || ph_program) |-> busy_pd);
  a_r4_program_follows_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_erase) |-> ph_program);
  a_r2_transfer_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_clear) |-> ph_transfer);
  a_r2_inhibit_in_phases: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_erase || ph_program || ph_clear || ph_transfer) |-> sram_inhibit);
  a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && !busy_in) |=> sram_inhibit);
  a_r7_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && cnt == '0 && busy_in) |=> (!busy_pd && !ph_erase));
  a_r13_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && !pwr_ok) |=> (!busy_pd && !ph_erase && !ph_clear));
endmodule

// File: tb/tb_nv_backup_seq.sv
module tb_nv_backup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE = 8, PROG = 12, CLR = 4, XFER = 6;
  localparam int ASRT = 5, DLY = 10, CHK = 3;

  logic clk = 0, rst_n = 0;
  logic pwr_ok = 0, acc_strobe = 0, wr_req = 0, sw_store = 0, sw_recall = 0;
  logic ext_pull = 0, ext_force_high = 0;
  logic busy_in, busy_pd, sram_inhibit, ph_erase, ph_program, ph_clear, ph_transfer;

  assign busy_in = ext_force_high ? 1'b1 : !(ext_pull || busy_pd);

  nv_backup_seq #(.ERASE_CYC(ERASE), .PROG_CYC(PROG), .CLR_CYC(CLR), .XFER_CYC(XFER),
    .ASSERT_CYC(ASRT), .DLY_CYC(DLY), .CHECK_CYC(CHK)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .busy_in(busy_in), .acc_strobe(acc_strobe),
    .wr_req(wr_req), .sw_store(sw_store), .sw_recall(sw_recall), .busy_pd(busy_pd),
    .sram_inhibit(sram_inhibit), .ph_erase(ph_erase), .ph_program(ph_program),
    .ph_clear(ph_clear), .ph_transfer(ph_transfer));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int expq[$];
  string reqq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_store(input string req);
    expq.push_back(0 * 256 + ERASE); reqq.push_back(req);
    expq.push_back(1 * 256 + PROG);  reqq.push_back(req);
  endtask

  task automatic expect_recall(input string req);
    expq.push_back(2 * 256 + CLR);  reqq.push_back(req);
    expq.push_back(3 * 256 + XFER); reqq.push_back(req);
  endtask

  // monitor: measures each phase run and compares with the queue
  int cur_code = -1, cur_len = 0;
  always @(negedge clk) begin
    logic [3:0] ph;
    int code;
    ph = {ph_transfer, ph_clear, ph_program, ph_erase};
    code = ph[0] ? 0 : ph[1] ? 1 : ph[2] ? 2 : ph[3] ? 3 : -1;
    if (code != cur_code && cur_code >= 0) begin
      if (expq.size() == 0) chk(0, "unexpected phase", cur_code * 256 + cur_len, -1);
      else begin
        int e;
        string r;
        e = expq.pop_front();
        r = reqq.pop_front();
        chk(e == cur_code * 256 + cur_len, r, cur_code * 256 + cur_len, e);
      end
      cur_len = 0;
    end
    cur_code = code;
    if (code >= 0) cur_len++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic summary;
    if (expq.size() != 0) chk(0, "missing phases", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    cyc(2); rst_n = 1;
    cyc(3);
    chk(sram_inhibit && !busy_pd && !ph_erase && !ph_clear, "R1 reset state", sram_inhibit, 1);

    pwr_ok = 1; expect_recall("R2 power-up recall");
    cyc(CLR + XFER + 3);
    chk(!sram_inhibit, "R2 enabled after recall", sram_inhibit, 0);

    expect_recall("R3 software recall");
    pulse(sw_recall); cyc(CLR + XFER + 3);
    chk(!sram_inhibit, "R3 enabled after recall", sram_inhibit, 0);

    expect_store("R4 software store without write");
    pulse(sw_store); cyc(3);
    chk(busy_pd, "R4 pull-down during store", busy_pd, 1);
    cyc(ERASE + PROG);
    chk(!busy_pd && !sram_inhibit, "R4 released after store", sram_inhibit, 0);

    ext_pull = 1; cyc(ASRT + 3);
    chk(sram_inhibit && !ph_erase, "R11 clean external request locks", sram_inhibit, 1);
    ext_pull = 0; cyc(2);
    chk(!sram_inhibit, "R10 release unlocks", sram_inhibit, 0);

    pulse(wr_req);
    ext_pull = 1; cyc(ASRT + 2);
    chk(!sram_inhibit && !ph_erase, "R8 window keeps SRAM enabled", sram_inhibit, 0);
    expect_store("R8 store after window");
    cyc(DLY + ERASE + PROG + 2);
    chk(sram_inhibit, "R10 locked while line low", sram_inhibit, 1);
    ext_pull = 0; cyc(2);
    chk(!sram_inhibit, "R10 unlocked after release", sram_inhibit, 0);

    ext_pull = 1; cyc(ASRT + 3);
    chk(!ph_erase && sram_inhibit, "R12 store skipped after clean", ph_erase, 0);
    ext_pull = 0; cyc(2);

    pulse(wr_req);
    ext_pull = 1; cyc(ASRT + 2);
    wr_req = 1; #1;
    chk(sram_inhibit, "R9 write in window blocked", sram_inhibit, 1);
    expect_store("R9 store on window exit");
    cyc(1); wr_req = 0; #1;
    chk(ph_erase, "R9 erase next cycle", ph_erase, 1);
    cyc(ERASE + PROG + 2);
    ext_pull = 0; cyc(2);

    pulse(wr_req);
    expect_store("R5 automatic store");
    pwr_ok = 0; cyc(1);
    chk(busy_pd && sram_inhibit, "R5 pull-down on power fall", busy_pd, 1);
    cyc(CHK + ERASE + PROG + 3);
    chk(sram_inhibit && !busy_pd, "R5 inhibited after store", sram_inhibit, 1);
    expect_recall("R2 brown-out recall");
    pwr_ok = 1; cyc(CLR + XFER + 3);

    pwr_ok = 0; cyc(2);
    chk(sram_inhibit && !busy_pd, "R6 clean power fall", busy_pd, 0);
    ext_pull = 1; cyc(ASRT + 4);
    chk(!busy_pd && !ph_erase && sram_inhibit, "R13 external ignored without power", busy_pd, 0);
    ext_pull = 0;
    expect_recall("R2 recall after clean fall");
    pwr_ok = 1; cyc(CLR + XFER + 3);

    pulse(wr_req);
    ext_force_high = 1; pwr_ok = 0; cyc(1);
    chk(busy_pd, "R7 attempt drives line", busy_pd, 1);
    cyc(CHK + 2);
    chk(!busy_pd && !ph_erase, "R7 attempt abandoned", busy_pd, 0);
    ext_force_high = 0; cyc(2);
    expect_recall("R7 recall after abort");
    pwr_ok = 1; cyc(CLR + XFER + 4);
    summary();
  end
endmodule